// File: doc/BRIEF.md
# Octet-Wide Self-Synchronizing Scrambler and Descrambler

This block holds two matching stages that whiten a byte stream one octet per clock before line coding, and restore it on the receive side. Both use the multiplicative form of the generator 1 + x^14 + x^15. Each output bit is the input bit XORed with the stream bits that lie 14 and 15 positions earlier in the scrambled stream. Because the receive stage builds its history from the bits it receives, it needs no seed exchange with the sender. After two data octets it holds the same 15-bit history as the transmitter, and from then on it restores the original data exactly. Whitening is optional on a link, so each stage has an enable. When the enable is low, octets pass unchanged, but the history still follows the stream so that whitening can resume cleanly.

Octets flagged as control characters pass through untouched and leave the history alone. This covers the comma and lane-alignment phases, where only control symbols are on the line. Bits are taken most-significant first within an octet. Each stage registers its output, so the latency is one clock. The reset value of each history register is a parameter.

Top module: `scr15_octet_pair`

## Requirements
- R1: While `rst_n` is low at a rising edge, both stages clear their output valid, data and control flags and load their history register from the seed parameter of that stage (`TX_SEED`, `RX_SEED`).
- R2: For a valid, enabled, non-control octet, the transmit output bit is the input bit XOR the scrambled-stream bits 14 and 15 positions earlier. Bit 7 is processed first and bit 0 last. The scrambled bits are shifted into the history.
- R3: For a valid, enabled, non-control octet, the receive output is formed the same way, but the received bits (not the output bits) are shifted into the history.
- R4: With the transmit output looped into the receive input, the receive output equals the original data from the third non-control octet after reset onward, whatever the two seeds are.
- R5: With the enable low, a valid non-control octet appears unchanged at the output, and its eight bits are shifted into the history as stream bits.
- R6: A valid octet with the control flag set appears unchanged at the output with the control flag set, and the history does not move.
- R7: A cycle with the input valid low produces a cycle with the output valid low and leaves the history unchanged.
- R8: With a nonzero history and all-zero enabled input, the transmit output repeats with a period of 32,767 bits, so octet k equals octet k + 32,767.
- R9: Every valid input octet yields exactly one valid output octet, one clock later, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both stages |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Transmit octet present |
| tx_en | input | 1 | Transmit whitening on (1) or bypassed (0) |
| tx_ctrl | input | 1 | Transmit octet is a control character |
| tx_data | input | OCTET_W | Transmit octet in |
| tx_out_valid | output | 1 | Transmit result present |
| tx_out_ctrl | output | 1 | Control flag carried with transmit result |
| tx_out_data | output | OCTET_W | Scrambled octet out |
| rx_valid | input | 1 | Received octet present |
| rx_en | input | 1 | Receive de-whitening on (1) or bypassed (0) |
| rx_ctrl | input | 1 | Received octet is a control character |
| rx_data | input | OCTET_W | Received scrambled octet |
| rx_out_valid | output | 1 | Receive result present |
| rx_out_ctrl | output | 1 | Control flag carried with receive result |
| rx_out_data | output | OCTET_W | Restored octet out |

## Verification
A transmit result is due one clock after its octet is captured. In the bench the transmit output is looped into the receive input, so the restored octet is due two clocks after the original was captured. The driver changes inputs on the falling edge and queues the expected transmit and receive items. A monitor pops and compares them on later falling edges, only in cycles where the matching output valid is high, so each result is sampled half a clock after the edge that produced it. A valid result with nothing queued, or items left in a queue at the end, marks a broken latency or a lost octet. Receive items from the first two data octets after reset are marked as not checked, because the receive history has not yet locked.

// File: rtl/scr15_pkg.sv
// Shared constants and types for the octet-wide self-synchronizing
// scrambler pair. Assumes the 1 + x^14 + x^15 generator.
package scr15_pkg;

    // Direction of a stage: which bits feed its history register.
    typedef enum logic {
        MODE_SCRAMBLE   = 1'b0,
        MODE_DESCRAMBLE = 1'b1
    } scr_mode_e;

    localparam int OCTET_BITS = 8;   // bits handled per clock
    localparam int HIST_BITS  = 15;  // history length = highest tap
    localparam int TAP_NEAR   = 14;  // first feedback tap (delay in bits)
    localparam int TAP_FAR    = 15;  // second feedback tap (delay in bits)

endpackage

// File: rtl/scr15_mix_net.sv
// Combinational bit network for one octet.
// It unrolls OCTET_W bit steps of a multiplicative scrambler, MSB first.
// Each step XORs the data bit with the history bits TAP_A and TAP_B
// positions back. The step then shifts the stream bit into the history.
// In scramble mode the stream bit is the XOR result; in descramble mode
// it is the incoming bit.
// Assumes: hist[0] holds the most recent stream bit,
// and TAP_A, TAP_B <= HIST_W.
module scr15_mix_net
    import scr15_pkg::*;
#(
    parameter int        OCTET_W = OCTET_BITS,
    parameter int        HIST_W  = HIST_BITS,
    parameter int        TAP_A   = TAP_NEAR,
    parameter int        TAP_B   = TAP_FAR,
    parameter scr_mode_e MODE    = MODE_SCRAMBLE
) (
    input  logic [HIST_W-1:0]  hist,
    input  logic [OCTET_W-1:0] din,
    output logic [OCTET_W-1:0] mixed,
    output logic [HIST_W-1:0]  next_hist
);

    localparam int STEPS = OCTET_W;

    // chain[k] is the history seen by bit step k
    logic [HIST_W-1:0]  chain [0:STEPS];
    logic [OCTET_W-1:0] stream;

    assign chain[0] = hist;

    // One bit step per data bit, most significant bit first
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        localparam int BIT = OCTET_W - 1 - k;
        logic fb;
        assign fb          = chain[k][TAP_A-1] ^ chain[k][TAP_B-1];
        assign mixed[BIT]  = din[BIT] ^ fb;
        assign stream[BIT] = (MODE == MODE_SCRAMBLE) ? mixed[BIT] : din[BIT];
        assign chain[k+1]  = {chain[k][HIST_W-2:0], stream[BIT]};
    end

    assign next_hist = chain[STEPS];

endmodule

// File: rtl/scr15_stage.sv
// One registered scrambler or descrambler stage, one octet per clock.
// Control octets pass unchanged and freeze the history.
// With the enable low, data passes unchanged and the raw octet is shifted
// into the history, so the stream stays continuous.
// Idle cycles (in_valid low) freeze the history.
// Assumes: HIST_W > OCTET_W, synchronous active-low reset.
module scr15_stage
    import scr15_pkg::*;
#(
    parameter int               OCTET_W = OCTET_BITS,
    parameter int               HIST_W  = HIST_BITS,
    parameter int               TAP_A   = TAP_NEAR,
    parameter int               TAP_B   = TAP_FAR,
    parameter scr_mode_e        MODE    = MODE_SCRAMBLE,
    parameter logic [HIST_W-1:0] SEED   = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_en,
    input  logic               in_ctrl,
    input  logic [OCTET_W-1:0] in_data,
    output logic               out_valid,
    output logic               out_ctrl,
    output logic [OCTET_W-1:0] out_data
);

    localparam int KEEP_W = HIST_W - OCTET_W;

    logic [HIST_W-1:0]  hist;
    logic [OCTET_W-1:0] net_mixed;
    logic [HIST_W-1:0]  net_next;
    logic [HIST_W-1:0]  raw_next;
    logic               pass_thru;

    scr15_mix_net #(
        .OCTET_W (OCTET_W),
        .HIST_W  (HIST_W),
        .TAP_A   (TAP_A),
        .TAP_B   (TAP_B),
        .MODE    (MODE)
    ) i_net (
        .hist      (hist),
        .din       (in_data),
        .mixed     (net_mixed),
        .next_hist (net_next)
    );

    // History after shifting the raw octet in, used when whitening is off
    assign raw_next  = {hist[KEEP_W-1:0], in_data};
    // Octet leaves the stage unmodified
    assign pass_thru = in_ctrl || !in_en;

    // Output register: valid every cycle, data and flag on valid octets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ctrl  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_ctrl <= in_ctrl;
                out_data <= pass_thru ? in_data : net_mixed;
            end
        end
    end

    // History register: advances only on valid data octets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= SEED;
        end else if (in_valid && !in_ctrl) begin
            hist <= in_en ? net_next : raw_next;
        end
    end

    // R1
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_ctrl && out_data == '0 && hist == SEED));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(hist)));

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    ctrl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl) |=>
            (out_ctrl && out_data == $past(in_data) && $stable(hist)));

    // R5
    bypass_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ctrl && !in_en) |=>
            (!out_ctrl && out_data == $past(in_data) &&
             hist[OCTET_W-1:0] == $past(in_data)));

    if (MODE == MODE_SCRAMBLE) begin : g_scr_chk
        // R2
        scr_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_ctrl && in_en) |=>
                (hist[OCTET_W-1:0] == out_data));
    end else begin : g_dsc_chk
        // R3
        dsc_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_ctrl && in_en) |=>
                (hist[OCTET_W-1:0] == $past(in_data)));
    end

endmodule

// File: rtl/scr15_octet_pair.sv
// Top of the scrambler pair: an independent transmit scrambler and
// receive descrambler sharing one clock and reset.
// Assumes: the receive side sees the same octet stream and enable pattern
// that the transmit side produced, with control octets flagged.
module scr15_octet_pair
    import scr15_pkg::*;
#(
    parameter int                OCTET_W = OCTET_BITS,
    parameter int                HIST_W  = HIST_BITS,
    parameter int                TAP_A   = TAP_NEAR,
    parameter int                TAP_B   = TAP_FAR,
    parameter logic [HIST_W-1:0] TX_SEED = '1,
    parameter logic [HIST_W-1:0] RX_SEED = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    input  logic               tx_en,
    input  logic               tx_ctrl,
    input  logic [OCTET_W-1:0] tx_data,
    output logic               tx_out_valid,
    output logic               tx_out_ctrl,
    output logic [OCTET_W-1:0] tx_out_data,
    input  logic               rx_valid,
    input  logic               rx_en,
    input  logic               rx_ctrl,
    input  logic [OCTET_W-1:0] rx_data,
    output logic               rx_out_valid,
    output logic               rx_out_ctrl,
    output logic [OCTET_W-1:0] rx_out_data
);

    scr15_stage #(
        .OCTET_W (OCTET_W),
        .HIST_W  (HIST_W),
        .TAP_A   (TAP_A),
        .TAP_B   (TAP_B),
        .MODE    (MODE_SCRAMBLE),
        .SEED    (TX_SEED)
    ) i_tx_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_en     (tx_en),
        .in_ctrl   (tx_ctrl),
        .in_data   (tx_data),
        .out_valid (tx_out_valid),
        .out_ctrl  (tx_out_ctrl),
        .out_data  (tx_out_data)
    );

    scr15_stage #(
        .OCTET_W (OCTET_W),
        .HIST_W  (HIST_W),
        .TAP_A   (TAP_A),
        .TAP_B   (TAP_B),
        .MODE    (MODE_DESCRAMBLE),
        .SEED    (RX_SEED)
    ) i_rx_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_en     (rx_en),
        .in_ctrl   (rx_ctrl),
        .in_data   (rx_data),
        .out_valid (rx_out_valid),
        .out_ctrl  (rx_out_ctrl),
        .out_data  (rx_out_data)
    );

endmodule

// File: tb/test_scr15_octet_pair.sv
`timescale 1ns/1ps
module test_scr15_octet_pair;

    localparam real CLK_NS     = 5.0;
    localparam int  WD_CYCLES  = 150000;
    localparam int  PERIOD_OCT = 32767;
    localparam logic [14:0] TXS = 15'h4D3B;
    localparam logic [14:0] RXS = 15'h12F0;

    typedef struct {
        logic [7:0] d;
        logic       c;
        logic       chk;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0, tx_en = 1'b1, tx_ctrl = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_out_valid, tx_out_ctrl;
    logic [7:0] tx_out_data;
    logic       rx_en_q = 1'b1;
    logic       rx_out_valid, rx_out_ctrl;
    logic [7:0] rx_out_data;

    int n_checks = 0;
    int n_fail   = 0;

    item_t       txq[$];
    item_t       rxq[$];
    logic [14:0] mdl_hist;
    int          lock_cnt;
    int          tx_seen;
    bit          period_mode = 0;
    logic [7:0]  first_oct [0:3];

    always #(CLK_NS/2.0) clk = ~clk;

    // receive enable follows transmit enable one octet later (loopback)
    always_ff @(posedge clk) rx_en_q <= tx_en;

    scr15_octet_pair #(
        .TX_SEED (TXS),
        .RX_SEED (RXS)
    ) i_scr15_octet_pair (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_valid     (tx_valid),
        .tx_en        (tx_en),
        .tx_ctrl      (tx_ctrl),
        .tx_data      (tx_data),
        .tx_out_valid (tx_out_valid),
        .tx_out_ctrl  (tx_out_ctrl),
        .tx_out_data  (tx_out_data),
        .rx_valid     (tx_out_valid),
        .rx_en        (rx_en_q),
        .rx_ctrl      (tx_out_ctrl),
        .rx_data      (tx_out_data),
        .rx_out_valid (rx_out_valid),
        .rx_out_ctrl  (rx_out_ctrl),
        .rx_out_data  (rx_out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit-serial reference of the generator, MSB first
    task automatic ref_scramble(input logic [7:0] d, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) begin
            o[i]     = d[i] ^ mdl_hist[13] ^ mdl_hist[14];
            mdl_hist = {mdl_hist[13:0], o[i]};
        end
    endtask

    // driver: present one octet and queue its expected results
    task automatic send(input logic [7:0] d, input logic en, input logic c, input string req);
        item_t t, r;
        logic [7:0] e;
        @(negedge clk);
        tx_valid = 1'b1; tx_en = en; tx_ctrl = c; tx_data = d;
        if (c) begin
            e = d;
        end else if (!en) begin
            e = d;
            for (int i = 7; i >= 0; i--) mdl_hist = {mdl_hist[13:0], d[i]};
        end else begin
            ref_scramble(d, e);
        end
        t.d = e; t.c = c; t.chk = 1'b1; t.req = req;
        r.d = d; r.c = c; r.chk = c ? 1'b1 : (lock_cnt >= 2); r.req = "R3/R4";
        txq.push_back(t);
        rxq.push_back(r);
        if (!c) lock_cnt++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        idle(4);
        @(negedge clk);
        rst_n = 1'b0;
        tx_valid = 1'b0;
        idle(3);
        check(!tx_out_valid && !rx_out_valid, "R1 valid low in reset",
              {tx_out_valid, rx_out_valid}, 0);
        check(tx_out_data == 8'h00 && !tx_out_ctrl, "R1 data clear in reset",
              tx_out_data, 0);
        mdl_hist = TXS;
        lock_cnt = 0;
        tx_seen  = 0;
        rst_n = 1'b1;
    endtask

    // monitor: compare outputs with the scoreboard half a clock after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_out_valid) begin
                if (txq.size() == 0) begin
                    check(0, "R9 unexpected tx output", tx_out_data, 0);
                end else begin
                    item_t t;
                    t = txq.pop_front();
                    check(tx_out_data == t.d && tx_out_ctrl == t.c, t.req,
                          {tx_out_ctrl, tx_out_data}, {t.c, t.d});
                    if (period_mode) begin
                        if (tx_seen < 4) first_oct[tx_seen] = tx_out_data;
                        if (tx_seen >= PERIOD_OCT && tx_seen < PERIOD_OCT + 4)
                            check(tx_out_data == first_oct[tx_seen - PERIOD_OCT],
                                  "R8 period repeat", tx_out_data,
                                  first_oct[tx_seen - PERIOD_OCT]);
                    end
                    tx_seen++;
                end
            end
            if (rx_out_valid) begin
                if (rxq.size() == 0) begin
                    check(0, "R9 unexpected rx output", rx_out_data, 0);
                end else begin
                    item_t r;
                    r = rxq.pop_front();
                    if (r.chk)
                        check(rx_out_data == r.d && rx_out_ctrl == r.c, r.req,
                              {rx_out_ctrl, rx_out_data}, {r.c, r.d});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stimulus
        mdl_hist = TXS;
        lock_cnt = 0;
        tx_seen  = 0;
        do_reset();
        // R1: first octet after reset is scrambled from the seed
        send(8'h00, 1'b1, 1'b0, "R1/R2 seed start");
        // R2, R4: varied data
        for (int i = 0; i < 24; i++) send(8'(i * 37 + 5), 1'b1, 1'b0, "R2 scramble");
        // R6: control octets interleaved with data
        send(8'hBC, 1'b1, 1'b1, "R6 control pass");
        send(8'h5A, 1'b1, 1'b0, "R2 after control");
        send(8'h1C, 1'b1, 1'b1, "R6 control pass");
        send(8'h7C, 1'b1, 1'b1, "R6 control pass");
        send(8'hA5, 1'b1, 1'b0, "R2 after control");
        // R5: whitening off then on again
        for (int i = 0; i < 6; i++) send(8'(8'hF0 + i), 1'b0, 1'b0, "R5 bypass");
        for (int i = 0; i < 8; i++) send(8'(i * 91), 1'b1, 1'b0, "R5 resume");
        // R7: idle gaps hold the history
        idle(3);
        send(8'h33, 1'b1, 1'b0, "R7 after idle");
        idle(1);
        send(8'hCC, 1'b1, 1'b0, "R7 after idle");
        // corner patterns
        for (int i = 0; i < 6; i++) send(8'hFF, 1'b1, 1'b0, "R2 all ones");
        for (int i = 0; i < 6; i++) send(8'h00, 1'b1, 1'b0, "R2 all zeros");
        idle(4);
        // R4: lock again from fresh seeds after a second reset
        do_reset();
        send(8'hBC, 1'b1, 1'b1, "R6 control before data");
        for (int i = 0; i < 12; i++) send(8'(i * 13 + 200), 1'b1, 1'b0, "R4 relock");
        idle(4);
        // R8: long zero run exposes the generator period
        do_reset();
        period_mode = 1;
        for (int i = 0; i < PERIOD_OCT + 4; i++) send(8'h00, 1'b1, 1'b0, "R8 zero run");
        idle(4);
        check(first_oct[0] != 8'h00 || first_oct[1] != 8'h00, "R8 nonzero sequence",
              first_oct[0], 1);
        // R9: nothing lost or left over
        check(txq.size() == 0 && rxq.size() == 0, "R9 queues drained",
              txq.size() + rxq.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule